// File: doc/BRIEF.md
# Stop-State Entry and Wake Sequencer

This block holds the one-byte control register that a small microcontroller writes to enter its deep stop state, and the state machine that brings it back out. Writing the register with its start bit set halts the core and the peripherals. The stop-release pin then ends the stop state. The pin acts either on a rising edge or on a high level, and a register bit picks which. The block then waits for a warm-up period so that the oscillator can settle. The length of this wait depends on a 2-bit code and on whether the system returns to the fast clock or the slow clock. Warm-up is counted in cycles of the clock the system returns to, and each clock arrives as a one-cycle count enable.

While the block is halted it drives the port output-enable. This signal can keep the pin levels or release them to high impedance. The release pin itself always goes to high impedance. The block also reports the selected return mode, and it raises a clock-stable flag once warm-up completes. At that moment the start bit clears by itself. A reset always brings the block back to fast-clock operation, whatever return mode was selected.

Top module: `stopseq_top`

## Requirements
- R1: After reset the register reads 0x00, halt is 0, clk_stable is 1, port_oe is 1, pin_hiz is 0 and ret_slow is 0.
- R2: The register bits are: bit 7 start, bit 6 release method, bit 5 return mode, bit 4 output hold, bits 3:2 warm-up code. A write in run state stores bits 7:2. Bits 1:0 always read 0.
- R3: A run-state write with bit 7 = 1 that is not refused under R5 sets halt = 1 and clk_stable = 0 in the next cycle, and bit 7 then reads 1.
- R4: With bit 6 = 0, the stop state ends only when the pin is high in a cycle after a cycle in which it was low. A pin that is already high at entry, or that falls, does not end it. Clock count enables have no effect before release.
- R5: With bit 6 = 1, a high pin ends the stop state. A start write with bit 6 = 1 while the pin is high does not halt the block: bit 7 reads 0 and bits 6:2 are stored.
- R6: With bit 5 = 0, the warm-up lasts 3·2^HF_SHIFT_A, 2^HF_SHIFT_A, 3·2^HF_SHIFT_B and 2^HF_SHIFT_B pulses of hf_tick for codes 00, 01, 10 and 11.
- R7: With bit 5 = 1, the warm-up lasts 3·2^LF_SHIFT_A, 2^LF_SHIFT_A, 3·2^LF_SHIFT_B and 2^LF_SHIFT_B pulses of lf_tick for those same codes. Pulses on the clock that is not selected are not counted.
- R8: In the cycle after the last counted pulse, halt falls, clk_stable rises and bit 7 reads 0. Until then halt stays 1.
- R9: While halted, port_oe equals bit 4 (0 means high impedance) and pin_hiz is 1, whatever bit 4 holds.
- R10: Writes while halted are ignored.
- R11: A reset while halted returns the block to run state with ret_slow = 0, even if bit 5 was 1.
- R12: ret_slow follows bit 5 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, also the reset-pin exit from stop |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wake_pin | input | 1 | Stop-release pin, synchronous to clk |
| hf_tick | input | 1 | One-cycle count enable per fast-clock cycle |
| lf_tick | input | 1 | One-cycle count enable per slow-clock cycle |
| halt | output | 1 | Core and peripheral halt |
| clk_stable | output | 1 | Warm-up complete, system clock usable |
| port_oe | output | 1 | Port drive enable (0 = high impedance) |
| pin_hiz | output | 1 | Release pin forced to high impedance |
| ret_slow | output | 1 | Selected return mode (1 = slow clock) |

## Verification
The entry decision and the level-mode release decision can fall in the same cycle. This happens when a start write with bit 6 set lands while the release pin is already high. The bench drives that write with the pin held high. It then expects halt to stay low, bit 7 to read 0 and the other fields to be kept. A second overlap is a warm-up pulse on the clock that is not selected arriving while the selected clock is counting. Each selected pulse is interleaved with one on the other clock, and halt must still be high one pulse before the programmed count and low exactly at it.

// File: rtl/stopseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the stop sequencer.
// Assumes the control register is one byte with its fields at fixed bits 7..2.
package stopseq_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       start;
        logic       lvl_rel;
        logic       slow_ret;
        logic       hold_out;
        logic [1:0] wut;
    } ctrl_fields_t;
endpackage

// File: rtl/stopseq_ctrl_reg.sv
`timescale 1ns/1ps
// Control register of the stop sequencer.
// Stores fields on an accepted write. The start bit is refused when the
// entry is blocked, and it clears when warm-up ends. Bits 1:0 always read zero.
// Assumes the caller accepts writes only in run state.
module stopseq_ctrl_reg
    import stopseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_take,
    input  logic [REG_W-1:0]   wdata,
    input  logic               block_entry,
    input  logic               clear_start,
    output ctrl_fields_t       fld,
    output logic [REG_W-1:0]   rdata
);
    localparam logic [1:0] LOW_MASK = 2'b00;

    logic [REG_W-1:0] reg_q;

    // Register update: accepted write, start self-clear, reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_take) begin
            reg_q <= {wdata[7] & ~block_entry, wdata[6:2], wdata[1:0] & LOW_MASK};
        end else if (clear_start) begin
            reg_q[7] <= 1'b0;
        end
    end

    // Field view and readback.
    always_comb begin
        fld   = reg_q[7:2];
        rdata = reg_q;
    end
endmodule

// File: rtl/stopseq_wake_detect.sv
`timescale 1ns/1ps
// Release decision for the stop state.
// Edge mode needs a low-to-high step between consecutive cycles. Level mode
// needs only a high pin. Assumes the pin is already synchronous to clk.
module stopseq_wake_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    output logic release_req,
    output logic pin_high
);
    logic pin_q;

    // Previous-cycle sample of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // Pick the release condition for the selected method.
    always_comb begin
        pin_high    = pin;
        release_req = level_mode ? pin : (pin & ~pin_q);
    end
endmodule

// File: rtl/stopseq_warmup_cnt.sv
`timescale 1ns/1ps
// Warm-up counter.
// Counts pulses of the clock that the system returns to, up to a length
// taken from a four-entry table of shifted values, and flags the last pulse.
// Assumes the code and the clock choice are stable while it is active.
module stopseq_warmup_cnt #(
    parameter int HF_SHIFT_A = 16,
    parameter int HF_SHIFT_B = 14,
    parameter int LF_SHIFT_A = 13,
    parameter int LF_SHIFT_B = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       active,
    input  logic       sel_slow,
    input  logic [1:0] code,
    input  logic       hf_tick,
    input  logic       lf_tick,
    output logic       done
);
    localparam int MAXS = (HF_SHIFT_A > LF_SHIFT_A) ? HF_SHIFT_A : LF_SHIFT_A;
    localparam int CW   = MAXS + 2;
    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] THREE = CW'(3);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;
    logic          tick_sel;

    // Table lookup of the wait length, per return clock and code.
    always_comb begin
        unique case ({sel_slow, code})
            3'b000:  target = THREE << HF_SHIFT_A;
            3'b001:  target = ONE   << HF_SHIFT_A;
            3'b010:  target = THREE << HF_SHIFT_B;
            3'b011:  target = ONE   << HF_SHIFT_B;
            3'b100:  target = THREE << LF_SHIFT_A;
            3'b101:  target = ONE   << LF_SHIFT_A;
            3'b110:  target = THREE << LF_SHIFT_B;
            default: target = ONE   << LF_SHIFT_B;
        endcase
        tick_sel = sel_slow ? lf_tick : hf_tick;
        done     = active & tick_sel & (cnt_q == target - ONE);
    end

    // Pulse counter, cleared when the stop state is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= '0;
        else if (active & tick_sel) cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/stopseq_top.sv
`timescale 1ns/1ps
// Stop sequencer top.
// Sequences run -> stop -> warm-up -> run. Accepts register writes only in
// run state and drives the halt, port and clock-stable outputs. Assumes the
// reset input also serves as the reset-pin exit from the stop state.
module stopseq_top
    import stopseq_pkg::*;
#(
    parameter int HF_SHIFT_A = 16,
    parameter int HF_SHIFT_B = 14,
    parameter int LF_SHIFT_A = 13,
    parameter int LF_SHIFT_B = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             wake_pin,
    input  logic             hf_tick,
    input  logic             lf_tick,
    output logic             halt,
    output logic             clk_stable,
    output logic             port_oe,
    output logic             pin_hiz,
    output logic             ret_slow
);
    seq_state_t   state_q;
    ctrl_fields_t fld;
    logic         wr_take;
    logic         block_entry;
    logic         enter;
    logic         release_req;
    logic         pin_high;
    logic         warm_load;
    logic         warm_done;

    // Write acceptance and the entry decision.
    always_comb begin
        wr_take     = reg_wr & (state_q == ST_RUN);
        block_entry = reg_wdata[6] & pin_high;
        enter       = wr_take & reg_wdata[7] & ~block_entry;
        warm_load   = (state_q == ST_STOP) & release_req;
    end

    stopseq_ctrl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_take     (wr_take),
        .wdata       (reg_wdata),
        .block_entry (block_entry),
        .clear_start (warm_done),
        .fld         (fld),
        .rdata       (reg_rdata)
    );

    stopseq_wake_detect u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin         (wake_pin),
        .level_mode  (fld.lvl_rel),
        .release_req (release_req),
        .pin_high    (pin_high)
    );

    stopseq_warmup_cnt #(
        .HF_SHIFT_A (HF_SHIFT_A),
        .HF_SHIFT_B (HF_SHIFT_B),
        .LF_SHIFT_A (LF_SHIFT_A),
        .LF_SHIFT_B (LF_SHIFT_B)
    ) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (warm_load),
        .active   (state_q == ST_WARM),
        .sel_slow (fld.slow_ret),
        .code     (fld.wut),
        .hf_tick  (hf_tick),
        .lf_tick  (lf_tick),
        .done     (warm_done)
    );

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:  if (enter)       state_q <= ST_STOP;
                ST_STOP: if (release_req) state_q <= ST_WARM;
                ST_WARM: if (warm_done)   state_q <= ST_RUN;
                default:                  state_q <= ST_RUN;
            endcase
        end
    end

    // Output decode from the state and the register fields.
    always_comb begin
        halt       = (state_q != ST_RUN);
        clk_stable = (state_q == ST_RUN);
        port_oe    = (state_q == ST_RUN) | fld.hold_out;
        pin_hiz    = (state_q != ST_RUN);
        ret_slow   = fld.slow_ret;
    end
endmodule

// File: rtl/stopseq_checker.sv
`timescale 1ns/1ps
// Property checker for the stop sequencer, bound to the top module.
// Assumes that reset is held for at least two cycles at start-up.
module stopseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       hf_tick,
    input logic       lf_tick,
    input logic       halt,
    input logic       clk_stable,
    input logic       port_oe,
    input logic       ret_slow
);
    // R1 and R11: run state with a cleared register right after reset.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!halt && clk_stable && reg_rdata == 8'h00 && !ret_slow));

    // R3: the halt output is raised only by a register write.
    p_entry_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(reg_wr));

    // R3: the start bit in the register agrees with the sequencer state.
    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] == halt);

    // R10: the register holds its value while halted.
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> $stable(reg_rdata));

    // R8: warm-up ends only on a clock pulse.
    p_end_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(halt) && $past(rst_n)) |-> $past(hf_tick || lf_tick));

    // R9: with output hold cleared, the ports are released while halted.
    p_port_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reg_rdata[4]) |-> !port_oe);
endmodule

bind stopseq_top stopseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .hf_tick    (hf_tick),
    .lf_tick    (lf_tick),
    .halt       (halt),
    .clk_stable (clk_stable),
    .port_oe    (port_oe),
    .ret_slow   (ret_slow)
);

// File: tb/stopseq_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for the stop sequencer. Driver tasks queue the expected
// outputs and a monitor compares them shortly after each falling edge.
module stopseq_top_tb_top;
    localparam int HA = 4;
    localparam int HB = 2;
    localparam int LA = 3;
    localparam int LB = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wake_pin = 1'b0;
    logic       hf_tick = 1'b0;
    logic       lf_tick = 1'b0;
    logic       halt, clk_stable, port_oe, pin_hiz, ret_slow;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string      req;
        logic [12:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    stopseq_top #(.HF_SHIFT_A(HA), .HF_SHIFT_B(HB), .LF_SHIFT_A(LA), .LF_SHIFT_B(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wake_pin(wake_pin), .hf_tick(hf_tick),
        .lf_tick(lf_tick), .halt(halt), .clk_stable(clk_stable),
        .port_oe(port_oe), .pin_hiz(pin_hiz), .ret_slow(ret_slow)
    );

    // Expected warm-up length from the requirement tables (R6, R7).
    function automatic int wait_len(bit slow, bit [1:0] code);
        int sa = slow ? LA : HA;
        int sb = slow ? LB : HB;
        case (code)
            2'd0:    return 3 << sa;
            2'd1:    return 1 << sa;
            2'd2:    return 3 << sb;
            default: return 1 << sb;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] rd, logic h, logic s, logic oe, logic hz, logic sl);
        item_t it;
        it.req = req;
        it.exp = {rd, h, s, oe, hz, sl};
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(bit slow);
        if (slow) lf_tick = 1'b1; else hf_tick = 1'b1;
        step();
        lf_tick = 1'b0;
        hf_tick = 1'b0;
    endtask

    task automatic release_pin();
        wake_pin = 1'b1;
        step();
        wake_pin = 1'b0;
    endtask

    // Runs warm-up, interleaving pulses on the other clock (R6, R7, R8).
    task automatic warm(bit slow, bit [1:0] code, logic [7:0] rd, bit hold);
        int n = wait_len(slow, code);
        for (int i = 1; i <= n; i++) begin
            pulse(~slow);
            pulse(slow);
            if (i == n - 1)
                chk(slow ? "R7" : "R6", rd, 1'b1, 1'b0, hold, 1'b1, slow);
            else if (i == n)
                chk("R8", rd & 8'h7F, 1'b0, 1'b1, 1'b1, 1'b0, slow);
        end
    endtask

    task automatic full_cycle(bit lvl, bit slow, bit [1:0] code, bit hold);
        logic [7:0] d = {1'b1, lvl, slow, hold, code, 2'b00};
        wake_pin = 1'b0;
        step();
        wr(d);
        chk("R3 R9", d, 1'b1, 1'b0, hold, 1'b1, slow);
        release_pin();
        warm(slow, code, d, hold);
    endtask

    // Monitor: compares the queued expectations against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [12:0] act;
                it  = sb_q.pop_front();
                act = {reg_rdata, halt, clk_stable, port_oe, pin_hiz, ret_slow};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver: the stimulus sequence.
    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

        wr(8'h7F);
        chk("R2 R12", 8'h7C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        wr(8'h03);
        chk("R2 R12", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

        // Edge mode, fast return, code 01, outputs released.
        wr(8'h84);
        chk("R3 R9", 8'h84, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        wr(8'h00);
        chk("R10", 8'h84, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) pulse(1'b0);
        chk("R4 ticks before release", 8'h84, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        release_pin();
        warm(1'b0, 2'd1, 8'h84, 1'b0);

        // Edge mode with the pin already high at entry.
        wake_pin = 1'b1;
        step();
        wr(8'h90);
        chk("R3 R9", 8'h90, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (3) step();
        chk("R4 high at entry", 8'h90, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        wake_pin = 1'b0;
        step();
        chk("R4 falling pin", 8'h90, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        release_pin();
        warm(1'b0, 2'd0, 8'h90, 1'b1);

        // Level mode refused while the pin is high.
        wake_pin = 1'b1;
        step();
        wr(8'hC8);
        chk("R5 refused", 8'h48, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        wake_pin = 1'b0;
        step();

        full_cycle(1'b1, 1'b1, 2'd2, 1'b0);
        full_cycle(1'b0, 1'b0, 2'd2, 1'b1);
        full_cycle(1'b0, 1'b0, 2'd3, 1'b0);
        full_cycle(1'b1, 1'b1, 2'd3, 1'b1);
        full_cycle(1'b0, 1'b1, 2'd1, 1'b0);
        full_cycle(1'b1, 1'b1, 2'd0, 1'b1);

        // Reset while halted with slow return selected.
        wr(8'hA0);
        chk("R11 R12", 8'hA0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk("R11", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

        step();
        step();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule